// File: doc/BRIEF.md
# Panel Power Sequencer

This block walks a display panel through its bring-up and shut-down. Each routine is a fixed, ordered list of register writes. Each write goes out through a separate command writer, using a level request and a one-cycle completion pulse. The steps live in a small internal script. Each step holds a register address, a payload length of zero, one or two bytes, the payload itself, a flag that asks for a one-millisecond pause after the step, and an end-of-script marker.

A power-up request starts the wake-up script. It opens with three bare 0x00 commands, each followed by a pause. A failure on any of these three ends the run at once. After them come the standby-exit, mode, power-rail, output-control and sleep-exit writes. The display-on command is sent last. Errors on those later steps do not stop the run: they are gathered and reported once, when the run ends. A power-down request runs the shorter sleep script. A request that would not change the panel state is dropped, and so is any request that arrives while a script is running.

The pause length is set by a cycles-per-millisecond parameter. A counter makes the pause.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `wr_req`, `panel_on` and `seq_err` are all 0.
- R2: Each step raises `wr_req` and holds `wr_addr`, `wr_len` and `wr_data` steady until the cycle in which `wr_done` is sampled high.
  - `wr_len` is the byte count (0, 1 or 2).
  - A one-byte payload sits in `wr_data[7:0]` with the upper byte zero.
  - A two-byte payload fills `wr_data[15:0]`, and the writer sends the high byte first.
  - For zero bytes, `wr_data` is 0.
- R3: Power-up issues, in this order (address/len/data):
  - 00/0/0000 three times;
  - B0/1/0017, BC/1/0080, 3B/1/0000, B0/1/0016;
  - B8/2/FFF9;
  - 11/0/0000;
  - 29/0/0000.
- R4: After each of the three opening 0x00 writes, no new request appears for at least `CYC_PER_MS*WAIT_MS` cycles after its `wr_done`.
- R5: A `wr_err` on any of the three opening writes ends the run at once: no further write is issued, `panel_on` stays 0 and `seq_err` goes to 1.
- R6: A `wr_err` on any later power-up step does not stop the run. `seq_err` stays 0 until the run ends and is then 1, and `panel_on` still becomes 1.
- R7: `panel_on` rises only after the display-on write (0x29) has completed.
- R8: Power-down issues 28/0/0000, B8/2/8002, 10/0/0000, B0/1/0000 in that order. `panel_on` falls after the last of these completes.
- R9: A power-up request while `panel_on` is 1, or a power-down request while it is 0, issues no write and changes no output.
- R10: Power-up and power-down requests that arrive while a script is running are ignored.
- R11: `seq_err` holds its value until a new run starts, and clears when that run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_req | input | 1 | One-cycle request to run the power-up script |
| pwr_dn_req | input | 1 | One-cycle request to run the power-down script |
| wr_req | output | 1 | Write request to the command writer, held until done |
| wr_addr | output | 8 | Panel register or command code |
| wr_len | output | 2 | Payload byte count, 0 to 2 |
| wr_data | output | 16 | Payload, high byte sent first when two bytes |
| wr_done | input | 1 | One-cycle completion pulse from the writer |
| wr_err | input | 1 | Failure flag, valid with `wr_done` |
| panel_on | output | 1 | Panel is in the active state |
| seq_err | output | 1 | Last run saw a transfer failure |

## Verification
Two functions can fall in the same cycle here: the completion of a script's final write, and the arrival of a fresh request. The bench provokes this by having its writer model raise a power-up request in the very cycle it returns `wr_done` for the last power-down write. It judges the outcome by checking two things: the scoreboard queue stays empty (no stray write appears), and `panel_on` ends at 0. The bench also fires a request in the middle of a run, and injects errors into both an opening write and a later write, to check abort versus deferred reporting.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int N_STEPS   = 14;
  localparam int UP_FIRST  = 0;
  localparam int DN_FIRST  = 10;
  localparam int N_WAKE    = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] reg_addr;
    logic [1:0]        nbytes;
    logic [DATA_W-1:0] payload;
    logic              hold_ms;
    logic              is_last;
  } step_t;

  function automatic step_t mk(input logic [ADDR_W-1:0] a, input logic [1:0] n,
                               input logic [DATA_W-1:0] d, input logic h, input logic l);
    step_t s;
    s.reg_addr = a;
    s.nbytes   = n;
    s.payload  = d;
    s.hold_ms  = h;
    s.is_last  = l;
    return s;
  endfunction

  // Script contents: wake-up steps first, sleep steps from DN_FIRST.
  function automatic step_t step_at(input int unsigned i);
    case (i)
      0, 1, 2: return mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      3:       return mk(8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0);
      4:       return mk(8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0);
      5:       return mk(8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0);
      6:       return mk(8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0);
      7:       return mk(8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0);
      8:       return mk(8'h11, 2'd0, 16'h0000, 1'b0, 1'b0);
      9:       return mk(8'h29, 2'd0, 16'h0000, 1'b0, 1'b1);
      10:      return mk(8'h28, 2'd0, 16'h0000, 1'b0, 1'b0);
      11:      return mk(8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0);
      12:      return mk(8'h10, 2'd0, 16'h0000, 1'b0, 1'b0);
      13:      return mk(8'hB0, 2'd1, 16'h0000, 1'b0, 1'b1);
      default: return mk(8'h00, 2'd0, 16'h0000, 1'b0, 1'b1);
    endcase
  endfunction

endpackage

// File: rtl/pps_script_rom.sv
module pps_script_rom
  import pps_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  assign step = step_at(int'(idx));

endmodule

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int WAIT_MS    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);

  localparam int LIM = CYC_PER_MS * WAIT_MS;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == CW'(LIM - 1)) begin
          running <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a pause in progress cannot end before its count is reached
  p_pause_runs_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !start && cnt != CW'(LIM - 1)) |=> (running && !expired));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int WAIT_MS    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up_req,
  input  logic              pwr_dn_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_len,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              panel_on,
  output logic              seq_err
);

  localparam int IDX_W = $clog2(N_STEPS);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ACK, S_WAIT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  step_t            cur;
  logic             going_up;
  logic             err_acc;
  logic             in_wake;
  logic             tmr_go;
  logic             tmr_exp;
  logic             step_done;
  logic             abort_now;

  pps_script_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (idx),
    .step (cur)
  );

  pps_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .WAIT_MS(WAIT_MS)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (tmr_go),
    .expired (tmr_exp)
  );

  assign in_wake   = going_up && (int'(idx) < UP_FIRST + N_WAKE);
  assign abort_now = (st == S_ACK) && wr_done && wr_err && in_wake;
  assign tmr_go    = (st == S_ACK) && wr_done && !abort_now && cur.hold_ms;
  assign step_done = ((st == S_ACK) && wr_done && !cur.hold_ms) ||
                     ((st == S_WAIT) && tmr_exp);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      going_up <= 1'b0;
      err_acc  <= 1'b0;
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_len   <= '0;
      wr_data  <= '0;
      panel_on <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (pwr_up_req && !panel_on) begin
            going_up <= 1'b1;
            idx      <= IDX_W'(UP_FIRST);
            err_acc  <= 1'b0;
            seq_err  <= 1'b0;
            st       <= S_LOAD;
          end else if (pwr_dn_req && panel_on) begin
            going_up <= 1'b0;
            idx      <= IDX_W'(DN_FIRST);
            err_acc  <= 1'b0;
            seq_err  <= 1'b0;
            st       <= S_LOAD;
          end
        end
        S_LOAD: begin
          wr_req  <= 1'b1;
          wr_addr <= cur.reg_addr;
          wr_len  <= cur.nbytes;
          wr_data <= cur.payload;
          st      <= S_ACK;
        end
        S_ACK: begin
          if (wr_done) begin
            wr_req <= 1'b0;
            if (abort_now) begin
              seq_err <= 1'b1;
              st      <= S_IDLE;
            end else begin
              err_acc <= err_acc | wr_err;
              if (cur.hold_ms) st <= S_WAIT;
            end
          end
        end
        default: ;
      endcase

      if (step_done) begin
        if (cur.is_last) begin
          st       <= S_IDLE;
          panel_on <= going_up;
          seq_err  <= err_acc | ((st == S_ACK) && wr_err);
        end else begin
          idx <= idx + 1'b1;
          st  <= S_LOAD;
        end
      end
    end
  end

  // R2: request fields stay put until the writer completes
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_len) && $stable(wr_data)));

  // R4: nothing is requested while a pause runs
  p_quiet_pause_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> !wr_req);

  // R5: an opening-write failure returns to idle with the error raised
  p_abort_r5: assert property (@(posedge clk) disable iff (rst)
    abort_now |=> (st == S_IDLE && !panel_on && seq_err && !wr_req));

  // R6: the error flag only rises as a run ends
  p_err_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err) |-> (st == S_IDLE));

  // R7: the panel becomes active only right after the display-on write
  p_on_after_display_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(panel_on) |-> (wr_addr == 8'h29 && !wr_req));

  // R8: the panel drops out only after the last sleep write
  p_off_after_sleep_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(panel_on) |-> (wr_addr == 8'hB0 && wr_data == '0 && !wr_req));

endmodule

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;

  localparam int CYC = 20;

  typedef struct packed {
    logic [7:0]  a;
    logic [1:0]  n;
    logic [15:0] d;
    logic        h;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_drv = 1'b0, up_poke = 1'b0, dn_drv = 1'b0;
  logic        pwr_up_req, pwr_dn_req;
  logic        wr_req, wr_done = 1'b0, wr_err = 1'b0;
  logic [7:0]  wr_addr;
  logic [1:0]  wr_len;
  logic [15:0] wr_data;
  logic        panel_on, seq_err;

  assign pwr_up_req = up_drv | up_poke;
  assign pwr_dn_req = dn_drv;

  panel_pwr_seq #(.CYC_PER_MS(CYC), .WAIT_MS(1)) i_panel_pwr_seq (
    .clk(clk), .rst(rst), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_done(wr_done), .wr_err(wr_err), .panel_on(panel_on), .seq_err(seq_err)
  );

  always #10 clk = ~clk;

  int    n_chk = 0, n_err = 0, cyc = 0, txn = 0, err_at = -1;
  bit    poke_last = 1'b0;
  item_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t up_item(input int k);
    case (k)
      0, 1, 2: return '{8'h00, 2'd0, 16'h0000, 1'b1};
      3:       return '{8'hB0, 2'd1, 16'h0017, 1'b0};
      4:       return '{8'hBC, 2'd1, 16'h0080, 1'b0};
      5:       return '{8'h3B, 2'd1, 16'h0000, 1'b0};
      6:       return '{8'hB0, 2'd1, 16'h0016, 1'b0};
      7:       return '{8'hB8, 2'd2, 16'hFFF9, 1'b0};
      8:       return '{8'h11, 2'd0, 16'h0000, 1'b0};
      default: return '{8'h29, 2'd0, 16'h0000, 1'b0};
    endcase
  endfunction

  function automatic item_t dn_item(input int k);
    case (k)
      0:       return '{8'h28, 2'd0, 16'h0000, 1'b0};
      1:       return '{8'hB8, 2'd2, 16'h8002, 1'b0};
      2:       return '{8'h10, 2'd0, 16'h0000, 1'b0};
      default: return '{8'hB0, 2'd1, 16'h0000, 1'b0};
    endcase
  endfunction

  // Driver side: expected writes go into the scoreboard queue
  task automatic push_up(input int cnt);
    for (int k = 0; k < cnt; k++) exp_q.push_back(up_item(k));
  endtask

  task automatic push_dn();
    for (int k = 0; k < 4; k++) exp_q.push_back(dn_item(k));
  endtask

  task automatic pulse_up();
    @(negedge clk); up_drv = 1'b1;
    @(negedge clk); up_drv = 1'b0;
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn_drv = 1'b1;
    @(negedge clk); dn_drv = 1'b0;
  endtask

  // Monitor and writer model: pops expected items as writes appear
  initial begin
    bit armed = 1'b0;
    int t_done = 0;
    forever begin
      @(negedge clk);
      if (wr_req && !rst) begin
        item_t got, want;
        int my;
        bit last_dn;
        got = '{wr_addr, wr_len, wr_data, 1'b0};
        my = txn; txn++;
        if (armed) begin
          chk((cyc - t_done) >= CYC && (cyc - t_done) <= CYC + 8, "R4 pause length",
              cyc - t_done, CYC);
          armed = 1'b0;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected write", int'(wr_addr), 0);
          want = got;
        end else begin
          want = exp_q.pop_front();
          chk({got.a, got.n, got.d} == {want.a, want.n, want.d}, "R3 write content",
              int'({got.a, got.n, got.d}), int'({want.a, want.n, want.d}));
        end
        if (wr_addr == 8'h29) begin
          chk(panel_on == 1'b0, "R7 active before display-on done", int'(panel_on), 0);
          chk(seq_err == 1'b0, "R6 error flag raised mid-run", int'(seq_err), 0);
        end
        last_dn = (wr_addr == 8'hB0 && wr_len == 2'd1 && wr_data == 16'h0000);
        repeat (2) @(negedge clk);
        chk(wr_req && {wr_addr, wr_len, wr_data} == {got.a, got.n, got.d},
            "R2 request held", int'(wr_req), 1);
        wr_done = 1'b1;
        wr_err  = (my == err_at);
        if (poke_last && last_dn) up_poke = 1'b1;
        if (want.h && !wr_err) begin
          armed = 1'b1;
          t_done = cyc;
        end
        @(negedge clk);
        wr_done = 1'b0;
        wr_err  = 1'b0;
        up_poke = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wr_req == 1'b0, "R1 wr_req after reset", int'(wr_req), 0);
    chk(panel_on == 1'b0, "R1 panel_on after reset", int'(panel_on), 0);
    chk(seq_err == 1'b0, "R1 seq_err after reset", int'(seq_err), 0);

    // R9: power-down while already off
    t0 = txn;
    pulse_dn();
    repeat (40) @(negedge clk);
    chk(txn == t0, "R9 write on redundant power-down", txn - t0, 0);
    chk(panel_on == 1'b0, "R9 panel_on after redundant power-down", int'(panel_on), 0);

    // R3/R4/R7: clean power-up
    push_up(10);
    pulse_up();
    repeat (400) @(negedge clk);
    chk(panel_on == 1'b1, "R7 panel_on after power-up", int'(panel_on), 1);
    chk(seq_err == 1'b0, "R6 no error on clean run", int'(seq_err), 0);
    chk(exp_q.size() == 0, "R3 all power-up writes issued", exp_q.size(), 0);

    // R9: power-up while already on
    t0 = txn;
    pulse_up();
    repeat (40) @(negedge clk);
    chk(txn == t0, "R9 write on redundant power-up", txn - t0, 0);
    chk(panel_on == 1'b1, "R9 panel_on kept", int'(panel_on), 1);

    // R8/R10: power-down with requests during the run and on its last completion
    t0 = txn;
    push_dn();
    poke_last = 1'b1;
    pulse_dn();
    repeat (6) @(negedge clk);
    pulse_up();
    pulse_dn();
    repeat (200) @(negedge clk);
    poke_last = 1'b0;
    chk(panel_on == 1'b0, "R8 panel_on after power-down", int'(panel_on), 0);
    chk(exp_q.size() == 0, "R8 all power-down writes issued", exp_q.size(), 0);
    chk(txn - t0 == 4, "R10 writes during busy requests", txn - t0, 4);

    // R5: failure on the second opening write
    t0 = txn;
    push_up(2);
    err_at = txn + 1;
    pulse_up();
    repeat (400) @(negedge clk);
    chk(seq_err == 1'b1, "R5 error after opening failure", int'(seq_err), 1);
    chk(panel_on == 1'b0, "R5 panel stays off", int'(panel_on), 0);
    chk(txn - t0 == 2, "R5 writes stop at failure", txn - t0, 2);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

    // R6/R11: failure on a later step is deferred
    push_up(10);
    err_at = txn + 4;
    pulse_up();
    repeat (3) @(negedge clk);
    chk(seq_err == 1'b0, "R11 error cleared at new run", int'(seq_err), 0);
    repeat (400) @(negedge clk);
    chk(panel_on == 1'b1, "R6 panel on despite late failure", int'(panel_on), 1);
    chk(seq_err == 1'b1, "R6 error reported at end", int'(seq_err), 1);
    chk(exp_q.size() == 0, "R6 all writes issued", exp_q.size(), 0);

    // R11: error flag clears when power-down starts
    push_dn();
    pulse_dn();
    repeat (3) @(negedge clk);
    chk(seq_err == 1'b0, "R11 error cleared at power-down", int'(seq_err), 0);
    repeat (200) @(negedge clk);
    chk(panel_on == 1'b0, "R8 panel off at end", int'(panel_on), 0);
    chk(seq_err == 1'b0, "R11 clean power-down", int'(seq_err), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule